// File: doc/BRIEF.md
# Framed-Word UART Transmit Serializer

The block sends UART characters over one serial line. Each byte is wrapped in a fixed 11-bit word and sent least-significant bit first. The word holds a leading idle-high bit, a low start bit, the eight data bits and a high stop bit. A bit clock made from the system clock times each bit. A frame pulse, made inside the block, launches a new word every 13 bit periods. This leaves the line high for two bit periods between consecutive words.

Bytes enter through an eight-entry holding FIFO with a valid/ready handshake. An enable input starts and stops the serializer. After an enable, the first frame pulse comes only after a short ready delay plus one full frame period. Status outputs report a full FIFO and an empty holding stage. Two sticky flags record a write dropped while the FIFO was full and a frame pulse that found nothing to send. Each flag clears when a 1 is written to its bit of a clear input.

Top module: `wordframe_uart_tx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it drops, the outputs are `txd`=1, `in_ready`=1, `hold_empty`=1, `fifo_full`=0, `ovf_flag`=0 and `unf_flag`=0.
- R2: Each byte is sent as an 11-bit word, least-significant bit first. Word bit 0 is 1. Bit 1 is the start bit, 0. Bits 2 to 9 carry the data, with data bit 0 in word bit 2. Bit 10 is the stop bit, 1. Every bit lasts 2*(`div_val`+1) clock cycles.
- R3: Count the first clock edge that samples `en` high as edge 1, and let P be the bit period in cycles. The first frame pulse falls at edge 16*P. The start bit of a word loaded by that pulse appears at edge 17*P.
- R4: Frame pulses come every 13 bit periods. For back-to-back words, the start bits are 13*P cycles apart. The line stays high for the two bit periods after each stop bit.
- R5: `txd` is 1 from the first clock edge that samples `en` low, even in the middle of a word. It also stays 1 while no word is being sent.
- R6: The FIFO holds 8 bytes and sends them in write order. `fifo_full` is 1 exactly when 8 bytes are held, and `in_ready` is then 0.
- R7: If `in_valid` is high while `fifo_full` is 1, the byte is dropped and `ovf_flag` is set. The flag stays set until a cycle with `flag_clr[1]`=1.
- R8: A frame pulse that finds the FIFO empty sends nothing and sets `unf_flag`. The flag stays set until a cycle with `flag_clr[0]`=1. A set in the same cycle wins over a clear.
- R9: `hold_empty` is 1 exactly when the FIFO holds no byte. It rises at the frame pulse that takes out the last byte, while that word is still being sent.
- R10: Bytes stay in the FIFO while `en` is low. Each new enable restarts the R3 timing from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Serializer enable |
| div_val | input | DIV_W | Bit clock divider; bit period is 2*(div_val+1) cycles. Change only while `en` is low |
| in_data | input | 8 | Byte to queue |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | FIFO can accept a byte |
| flag_clr | input | 2 | Write-1 clear: bit 0 underflow, bit 1 overflow |
| txd | output | 1 | Serial line, idle high |
| fifo_full | output | 1 | FIFO holds 8 bytes |
| hold_empty | output | 1 | FIFO holds no byte |
| ovf_flag | output | 1 | Sticky dropped-write flag |
| unf_flag | output | 1 | Sticky empty-frame flag |

## Verification
A frame sequencer that is one tick off moves the start edge by a whole bit period. This shows up at the first start bit after an enable, and again in the 13-period spacing of every later word. A wrong shifter or bit counter garbles the word within one frame: a data bit, the stop bit or the idle-high gap comes out wrong. A FIFO pointer or count error shows when eight stored bytes come out in the wrong order or with an extra byte. It also shows in the full and empty flags one cycle after the write or the frame pulse.

// File: rtl/wf_tx_pkg.sv
package wf_tx_pkg;
  localparam int DATA_W      = 8;
  localparam int WORD_BITS   = DATA_W + 3;   // idle-high, start, data, stop
  localparam int FRAME_TICKS = 13;           // bit periods between frame pulses
  localparam int READY_TICKS = 3;            // ready delay after enable
  localparam int LEAD_TICKS  = READY_TICKS + FRAME_TICKS;

  typedef logic [WORD_BITS-1:0] word_t;
  typedef logic [DATA_W-1:0]    byte_t;

  // Bit 0 high, bit 1 start (low), data LSB first from bit 2, stop bit on top.
  function automatic word_t make_word(input byte_t d);
    return {1'b1, d, 1'b0, 1'b1};
  endfunction
endpackage

// File: rtl/wf_bitclk.sv
module wf_bitclk #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // 2*(div_val+1)-1 is div_val shifted left with a one appended
  assign last = {div_val, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt == last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == last);
endmodule

// File: rtl/wf_fifo.sv
module wf_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count, count_nxt;
  logic              do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    count_nxt = count;
    if (do_push && !do_pop) count_nxt = count + 1'b1;
    if (do_pop && !do_push) count_nxt = count - 1'b1;
  end

  // storage has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
      count <= count_nxt;
      full  <= (count_nxt == CNT_MAX);
      empty <= (count_nxt == '0);
    end
  end
endmodule

// File: rtl/wf_framer.sv
module wf_framer
  import wf_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  tick,
  input  logic  fifo_empty,
  input  byte_t fifo_data,
  output logic  pop,
  output logic  unf_set,
  output logic  txd
);
  localparam int SEQ_W  = $clog2(LEAD_TICKS);
  localparam int LEFT_W = $clog2(WORD_BITS);
  localparam logic [SEQ_W-1:0]  SEQ_LEAD  = SEQ_W'(LEAD_TICKS - 1);
  localparam logic [SEQ_W-1:0]  SEQ_FRAME = SEQ_W'(FRAME_TICKS - 1);
  localparam logic [LEFT_W-1:0] LEFT_INIT = LEFT_W'(WORD_BITS - 1);

  logic [SEQ_W-1:0]     seq;
  logic                 fs;
  logic [WORD_BITS-2:0] sh;
  logic [LEFT_W-1:0]    left;
  word_t                word;

  // countdown to the next frame pulse; first pulse includes the ready delay
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      seq <= SEQ_LEAD;
    end else if (tick) begin
      seq <= (seq == '0) ? SEQ_FRAME : seq - 1'b1;
    end
  end

  assign fs      = tick && (seq == '0);
  assign pop     = fs && !fifo_empty;
  assign unf_set = fs && fifo_empty;
  assign word    = make_word(fifo_data);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      txd  <= 1'b1;
      sh   <= '1;
      left <= '0;
    end else if (tick) begin
      if (pop) begin
        txd  <= word[0];
        sh   <= word[WORD_BITS-1:1];
        left <= LEFT_INIT;
      end else if (left != '0) begin
        txd  <= sh[0];
        sh   <= {1'b1, sh[WORD_BITS-2:1]};
        left <= left - 1'b1;
      end else begin
        txd <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wordframe_uart_tx.sv
module wordframe_uart_tx
  import wf_tx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       flag_clr,
  output logic             txd,
  output logic             fifo_full,
  output logic             hold_empty,
  output logic             ovf_flag,
  output logic             unf_flag
);
  logic  tick, pop, unf_set, f_full, f_empty;
  byte_t f_data;

  wf_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .en(en), .div_val(div_val), .tick(tick)
  );

  wf_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(in_valid), .wr_data(in_data), .pop(pop),
    .rd_data(f_data), .full(f_full), .empty(f_empty)
  );

  wf_framer u_frm (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .fifo_empty(f_empty),
    .fifo_data(f_data), .pop(pop), .unf_set(unf_set), .txd(txd)
  );

  assign fifo_full  = f_full;
  assign hold_empty = f_empty;
  assign in_ready   = !f_full;

  // sticky flags: a set in the same cycle wins over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      if (in_valid && f_full)  ovf_flag <= 1'b1;
      else if (flag_clr[1])    ovf_flag <= 1'b0;
      if (unf_set)             unf_flag <= 1'b1;
      else if (flag_clr[0])    unf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wf_tx_chk.sv
module wf_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       in_valid,
  input logic [1:0] flag_clr,
  input logic       txd,
  input logic       fifo_full,
  input logic       hold_empty,
  input logic       ovf_flag,
  input logic       unf_flag
);
  p_idle_when_off_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> txd);

  p_start_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(txd) |-> $past(en));

  p_ovf_set_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fifo_full) |=> ovf_flag);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !flag_clr[1]) |=> ovf_flag);

  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (unf_flag && !flag_clr[0]) |=> unf_flag);

  p_full_not_empty_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !hold_empty);
endmodule

bind wordframe_uart_tx wf_tx_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .flag_clr(flag_clr),
  .txd(txd), .fifo_full(fifo_full), .hold_empty(hold_empty),
  .ovf_flag(ovf_flag), .unf_flag(unf_flag)
);

// File: tb/sim_wordframe_uart_tx.sv
`timescale 1ns/1ps
module sim_wordframe_uart_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] div_val = 16'd1;
  logic [7:0]  in_data = 8'h00;
  logic        in_valid = 1'b0;
  logic [1:0]  flag_clr = 2'b00;
  logic        in_ready, txd, fifo_full, hold_empty, ovf_flag, unf_flag;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wordframe_uart_tx u0 (
    .clk(clk), .rst(rst), .en(en), .div_val(div_val), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .flag_clr(flag_clr), .txd(txd),
    .fifo_full(fifo_full), .hold_empty(hold_empty), .ovf_flag(ovf_flag),
    .unf_flag(unf_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_clr(input logic [1:0] m);
    @(negedge clk);
    flag_clr = m;
    @(negedge clk);
    flag_clr = 2'b00;
  endtask

  // Wait for a start bit, then sample every bit mid-period; checks format and gap.
  task automatic rx_word(input int p, output logic [7:0] b, output int n0);
    bit seen = 0;
    b = 8'h00;
    n0 = -1;
    for (int i = 0; i < 40 * p; i++) begin
      @(negedge clk);
      if (txd == 1'b0) begin seen = 1; break; end
    end
    chk("R2 start bit seen", int'(seen), 1);
    if (!seen) return;
    n0 = cyc;
    repeat (p / 2) @(negedge clk);
    chk("R2 start bit low", int'(txd), 0);
    for (int j = 0; j < 8; j++) begin
      repeat (p) @(negedge clk);
      b[j] = txd;
    end
    repeat (p) @(negedge clk);
    chk("R2 stop bit high", int'(txd), 1);
    for (int k = 0; k < 3; k++) begin
      repeat (p) @(negedge clk);
      chk("R4 gap and leading bit high", int'(txd), 1);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 txd", int'(txd), 1);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 hold_empty", int'(hold_empty), 1);
    chk("R1 fifo_full", int'(fifo_full), 0);
    chk("R1 ovf_flag", int'(ovf_flag), 0);
    chk("R1 unf_flag", int'(unf_flag), 0);
  endtask

  // single word from a fresh enable, at a given divider
  task automatic t_first_word(input logic [15:0] dv, input logic [7:0] b);
    int p, cen, n0, lows;
    logic [7:0] got;
    p = 2 * (int'(dv) + 1);
    @(negedge clk);
    en = 1'b0;
    div_val = dv;
    push(b);
    chk("R9 hold_empty low with data", int'(hold_empty), 0);
    lows = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    chk("R5 line high while disabled", lows, 0);
    en = 1'b1;
    cen = cyc;
    rx_word(p, got, n0);
    chk("R2 data byte", int'(got), int'(b));
    chk("R3 first start edge", n0 - cen, 17 * p);
  endtask

  task automatic t_back_to_back;
    logic [7:0] exp_b [3];
    logic [7:0] got;
    int n0, prev;
    exp_b[0] = 8'h3C; exp_b[1] = 8'hFF; exp_b[2] = 8'h00;
    for (int i = 0; i < 3; i++) push(exp_b[i]);
    prev = -1;
    for (int i = 0; i < 3; i++) begin
      rx_word(4, got, n0);
      chk("R2 back-to-back data", int'(got), int'(exp_b[i]));
      if (i == 2) chk("R9 hold_empty while last word shifts", int'(hold_empty), 1);
      if (prev >= 0) chk("R4 start spacing 13 periods", n0 - prev, 13 * 4);
      prev = n0;
    end
  endtask

  task automatic t_underflow;
    int lows = 0;
    bit seen = 0;
    pulse_clr(2'b01);
    for (int i = 0; i < 14 * 4 + 4; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
      if (unf_flag) begin seen = 1; break; end
    end
    chk("R8 underflow set on empty frame", int'(seen), 1);
    chk("R8 nothing sent on empty frame", lows, 0);
    @(negedge clk);
    chk("R8 underflow sticky", int'(unf_flag), 1);
    pulse_clr(2'b01);
    chk("R8 underflow cleared by write-1", int'(unf_flag), 0);
  endtask

  task automatic t_full_overflow;
    logic [7:0] got;
    int n0, cen, lows;
    @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
    chk("R6 full at 8 entries", int'(fifo_full), 1);
    chk("R6 in_ready low when full", int'(in_ready), 0);
    chk("R7 no overflow yet", int'(ovf_flag), 0);
    push(8'hEE);
    chk("R7 overflow set", int'(ovf_flag), 1);
    chk("R6 still full", int'(fifo_full), 1);
    pulse_clr(2'b10);
    chk("R7 overflow cleared", int'(ovf_flag), 0);
    en = 1'b1;
    cen = cyc;
    for (int i = 0; i < 8; i++) begin
      rx_word(4, got, n0);
      chk("R6 in-order data", int'(got), 16 + i);
      if (i == 0) chk("R10 restart timing", n0 - cen, 17 * 4);
      if (i == 0) chk("R6 not full after pop", int'(fifo_full), 0);
    end
    lows = 0;
    for (int i = 0; i < 14 * 4; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    chk("R7 dropped byte never sent", lows, 0);
    chk("R9 hold_empty after drain", int'(hold_empty), 1);
    chk("R8 underflow after drain", int'(unf_flag), 1);
  endtask

  task automatic t_disable_mid_word;
    int lows = 0;
    bit seen = 0;
    @(negedge clk);
    en = 1'b0;
    div_val = 16'd1;
    push(8'h00);
    en = 1'b1;
    for (int i = 0; i < 40 * 4; i++) begin
      @(negedge clk);
      if (txd == 1'b0) begin seen = 1; break; end
    end
    chk("R5 word started", int'(seen), 1);
    repeat (8) @(negedge clk);
    chk("R2 data bit low", int'(txd), 0);
    en = 1'b0;
    @(negedge clk);
    chk("R5 high right after disable", int'(txd), 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    chk("R5 stays high while disabled", lows, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_first_word(16'd1, 8'hA5);
        t_back_to_back();
        t_underflow();
        t_full_overflow();
        t_first_word(16'd3, 8'h5A);
        t_first_word(16'd0, 8'hC3);
        t_disable_mid_word();
      end
      begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule